// File: doc/BRIEF.md
# OFDM Pilot Tone Inserter with Sign Scrambling

This block sits in an OFDM transmit path ahead of the inverse transform and writes two pilot tones into every OFDM symbol for a two-antenna transmitter. Subcarriers arrive one per clock, each with a 6-bit subcarrier index, a valid flag and a start-of-symbol marker. Each pilot is placed at two programmable indices, meant to mirror each other about DC. At those indices the incoming data is replaced by that pilot's real-valued, antenna-specific amplitude. All other subcarriers pass through unchanged.

An optional scrambler gives all pilots of one symbol a shared pseudo-random sign, which changes from symbol to symbol. The sign comes from a 7-bit LFSR with polynomial x^7+x^4+1. A packet-start pulse reloads the LFSR so that every packet begins the same sign sequence. In single-antenna mode the second antenna output is silenced.

Top module: `pilot_inserter`

## Requirements
- R1: Outputs are registered with one cycle of latency. `outValid`, `outSof` and `outIdx` follow `inValid`, `inSof` (qualified by `inValid`) and `inIdx` one cycle later. A non-pilot subcarrier's 32-bit word, real part in bits [31:16] and imaginary part in bits [15:0], is passed through unchanged.
- R2: A valid subcarrier whose index equals `p1IdxLo` or `p1IdxHi` is output as the pilot 1 value of that antenna in bits [31:16], with bits [15:0] set to zero.
- R3: A valid subcarrier whose index equals `p2IdxLo` or `p2IdxHi`, and matches neither pilot 1 index, is output as the pilot 2 value of that antenna in the same layout.
- R4: When an index matches both a pilot 1 and a pilot 2 setting, pilot 1 is inserted.
- R5: Antenna A carries `p1ValA`/`p2ValA` and antenna B carries `p1ValB`/`p2ValB`. These are independent signed values with 15 fraction bits.
- R6: While `sisoMode` is 1, every valid output word on antenna B is zero, pilot or not.
- R7: The LFSR (state s[6:0]) steps once at each valid start-of-symbol. The new bit is s[6]^s[3], and the state becomes {s[5:0], bit}. With `scrambleEn` high, that bit negates every pilot in the symbol when it is 1. From the all-ones seed the sign sequence is 0,0,0,0,1,...
- R8: With `scrambleEn` low no pilot is negated, but the LFSR keeps stepping at every symbol. When scrambling is enabled again, the sequence continues from its current position.
- R9: `pktStart` reloads the LFSR with all ones. If it arrives in the same cycle as a valid start-of-symbol, that symbol already uses the first bit of the new sequence.
- R10: Negating the pilot value 0x8000 gives 0x7FFF.
- R11: A cycle with `inValid` low drives `outValid` and `outSof` low on the next cycle and leaves both data outputs unchanged. Such a cycle does not step the LFSR, even if `inSof` is high.
- R12: After reset, all outputs are zero and the LFSR holds all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pktStart | input | 1 | Reloads the sign LFSR seed |
| scrambleEn | input | 1 | Applies the per-symbol pilot sign |
| sisoMode | input | 1 | Silences antenna B |
| p1IdxLo | input | 6 | First subcarrier index of pilot 1 |
| p1IdxHi | input | 6 | Mirror subcarrier index of pilot 1 |
| p2IdxLo | input | 6 | First subcarrier index of pilot 2 |
| p2IdxHi | input | 6 | Mirror subcarrier index of pilot 2 |
| p1ValA | input | 16 | Pilot 1 amplitude, antenna A |
| p1ValB | input | 16 | Pilot 1 amplitude, antenna B |
| p2ValA | input | 16 | Pilot 2 amplitude, antenna A |
| p2ValB | input | 16 | Pilot 2 amplitude, antenna B |
| inValid | input | 1 | Input subcarrier valid |
| inSof | input | 1 | First subcarrier of a symbol |
| inIdx | input | 6 | Subcarrier index |
| inDataA | input | 32 | Antenna A subcarrier {re, im} |
| inDataB | input | 32 | Antenna B subcarrier {re, im} |
| outValid | output | 1 | Output valid |
| outSof | output | 1 | Output start-of-symbol |
| outIdx | output | 6 | Output subcarrier index |
| outDataA | output | 32 | Antenna A output {re, im} |
| outDataB | output | 32 | Antenna B output {re, im} |

## Verification
A corrupt LFSR state or a missed or extra step does not show at once. It appears only on the pilot subcarriers of later symbols, as a wrong pilot sign, so the bench runs many consecutive symbols and checks every pilot's sign against a step-by-step sign model. A faulty index comparison or priority shows on the very next cycle, on the one subcarrier concerned. Full 64-index sweeps expose it, and they also expose a stuck SISO gate or a missing saturation on the first affected word.

// File: rtl/pilot_ins_pkg.sv
package pilot_ins_pkg;
  localparam int IDX_W   = 6;
  localparam int SAMP_W  = 16;
  localparam int NUM_ANT = 2;
  localparam int LFSR_W  = 7;
  localparam int TAP_HI  = 7;
  localparam int TAP_LO  = 4;

  typedef struct packed {
    logic valid;
    logic sof;
    logic selP1;
    logic selP2;
    logic negate;
  } strobe_t;
endpackage

// File: rtl/pilot_ins_ctrl.sv
module pilot_ins_ctrl
  import pilot_ins_pkg::*;
#(
  parameter int IW  = IDX_W,
  parameter int LW  = LFSR_W,
  parameter int THI = TAP_HI,
  parameter int TLO = TAP_LO
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pktStart,
  input  logic          scrambleEn,
  input  logic          inValid,
  input  logic          inSof,
  input  logic [IW-1:0] inIdx,
  input  logic [IW-1:0] p1IdxLo,
  input  logic [IW-1:0] p1IdxHi,
  input  logic [IW-1:0] p2IdxLo,
  input  logic [IW-1:0] p2IdxHi,
  output strobe_t       stb
);
  localparam int NUM_CMP = 4;
  localparam logic [LW-1:0] SEED = '1;

  logic [LW-1:0] lfsrQ;
  logic [LW-1:0] effState;
  logic          signQ;
  logic          fbBit;
  logic          symStart;
  logic          curBit;
  logic [IW-1:0] idxCfg [NUM_CMP];
  logic [NUM_CMP-1:0] hitVec;

  assign idxCfg[0] = p1IdxLo;
  assign idxCfg[1] = p1IdxHi;
  assign idxCfg[2] = p2IdxLo;
  assign idxCfg[3] = p2IdxHi;

  for (genvar k = 0; k < NUM_CMP; k++) begin : g_cmp
    assign hitVec[k] = (inIdx == idxCfg[k]);
  end

  assign symStart = inValid & inSof;
  assign effState = pktStart ? SEED : lfsrQ;
  assign fbBit    = effState[THI-1] ^ effState[TLO-1];
  assign curBit   = symStart ? fbBit : signQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lfsrQ <= SEED;
      signQ <= 1'b0;
    end else if (symStart) begin
      lfsrQ <= {effState[LW-2:0], fbBit};
      signQ <= fbBit;
    end else begin
      lfsrQ <= effState;
    end
  end

  always_comb begin
    stb.valid  = inValid;
    stb.sof    = symStart;
    stb.selP1  = inValid & (hitVec[0] | hitVec[1]);
    stb.selP2  = inValid & (hitVec[2] | hitVec[3]) & ~(hitVec[0] | hitVec[1]);
    stb.negate = scrambleEn & curBit;
  end

  // R7: a register of this kind never reaches the all-zero lock-up state
  p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rstN)
    lfsrQ != '0);

  p_reseed_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pktStart && !symStart) |=> (lfsrQ == SEED));

  p_no_step_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!symStart && !pktStart) |=> $stable(lfsrQ));

  p_one_pilot_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.selP1, stb.selP2}));
endmodule

// File: rtl/pilot_ins_dp.sv
module pilot_ins_dp
  import pilot_ins_pkg::*;
#(
  parameter int IW = IDX_W,
  parameter int SW = SAMP_W,
  parameter int NA = NUM_ANT
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic            sisoMode,
  input  logic [IW-1:0]   inIdx,
  input  logic [2*SW-1:0] inData   [NA],
  input  logic [SW-1:0]   pilotOne [NA],
  input  logic [SW-1:0]   pilotTwo [NA],
  output logic            outValid,
  output logic            outSof,
  output logic [IW-1:0]   outIdx,
  output logic [2*SW-1:0] outData  [NA]
);
  localparam logic [SW-1:0] MIN_VAL = {1'b1, {(SW-1){1'b0}}};
  localparam logic [SW-1:0] MAX_VAL = ~MIN_VAL;

  function automatic logic [SW-1:0] negSat(input logic [SW-1:0] v);
    if (v == MIN_VAL) return MAX_VAL;
    return ~v + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outSof   <= 1'b0;
      outIdx   <= '0;
    end else begin
      outValid <= stb.valid;
      outSof   <= stb.sof;
      if (stb.valid) outIdx <= inIdx;
    end
  end

  for (genvar a = 0; a < NA; a++) begin : g_ant
    localparam bit IS_AUX = (a > 0);
    logic [SW-1:0]   pv;
    logic [2*SW-1:0] nxt;

    always_comb begin
      pv = stb.selP1 ? pilotOne[a] : pilotTwo[a];
      if (stb.negate) pv = negSat(pv);
      if (IS_AUX && sisoMode)          nxt = '0;
      else if (stb.selP1 || stb.selP2) nxt = {pv, {SW{1'b0}}};
      else                             nxt = inData[a];
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)          outData[a] <= '0;
      else if (stb.valid) outData[a] <= nxt;
    end

    p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
      !stb.valid |=> $stable(outData[a]));

    p_sat_r10: assert property (@(posedge clk) disable iff (!rstN)
      (stb.valid && (stb.selP1 || stb.selP2) && stb.negate && !(IS_AUX && sisoMode))
        |=> (outData[a][2*SW-1 -: SW] != MIN_VAL));

    if (IS_AUX) begin : g_siso_chk
      p_siso_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
        (sisoMode && stb.valid) |=> (outData[a] == '0));
    end
  end

  p_latency_r1: assert property (@(posedge clk) disable iff (!rstN)
    stb.valid |=> outValid);

  p_gap_r11: assert property (@(posedge clk) disable iff (!rstN)
    !stb.valid |=> (!outValid && !outSof));

  p_sof_valid_r1: assert property (@(posedge clk) disable iff (!rstN)
    outSof |-> outValid);
endmodule

// File: rtl/pilot_inserter.sv
module pilot_inserter
  import pilot_ins_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pktStart,
  input  logic        scrambleEn,
  input  logic        sisoMode,
  input  logic [5:0]  p1IdxLo,
  input  logic [5:0]  p1IdxHi,
  input  logic [5:0]  p2IdxLo,
  input  logic [5:0]  p2IdxHi,
  input  logic [15:0] p1ValA,
  input  logic [15:0] p1ValB,
  input  logic [15:0] p2ValA,
  input  logic [15:0] p2ValB,
  input  logic        inValid,
  input  logic        inSof,
  input  logic [5:0]  inIdx,
  input  logic [31:0] inDataA,
  input  logic [31:0] inDataB,
  output logic        outValid,
  output logic        outSof,
  output logic [5:0]  outIdx,
  output logic [31:0] outDataA,
  output logic [31:0] outDataB
);
  strobe_t                stb;
  logic [2*SAMP_W-1:0]    dIn   [NUM_ANT];
  logic [2*SAMP_W-1:0]    dOut  [NUM_ANT];
  logic [SAMP_W-1:0]      pOne  [NUM_ANT];
  logic [SAMP_W-1:0]      pTwo  [NUM_ANT];

  assign dIn[0]  = inDataA;
  assign dIn[1]  = inDataB;
  assign pOne[0] = p1ValA;
  assign pOne[1] = p1ValB;
  assign pTwo[0] = p2ValA;
  assign pTwo[1] = p2ValB;
  assign outDataA = dOut[0];
  assign outDataB = dOut[1];

  pilot_ins_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .pktStart(pktStart), .scrambleEn(scrambleEn),
    .inValid(inValid), .inSof(inSof), .inIdx(inIdx),
    .p1IdxLo(p1IdxLo), .p1IdxHi(p1IdxHi), .p2IdxLo(p2IdxLo), .p2IdxHi(p2IdxHi),
    .stb(stb)
  );

  pilot_ins_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .sisoMode(sisoMode), .inIdx(inIdx),
    .inData(dIn), .pilotOne(pOne), .pilotTwo(pTwo),
    .outValid(outValid), .outSof(outSof), .outIdx(outIdx), .outData(dOut)
  );
endmodule

// File: tb/pilot_inserter_bench.sv
`timescale 1ns/1ps
module pilot_inserter_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        pktStart = 1'b0, scrambleEn = 1'b0, sisoMode = 1'b0;
  logic [5:0]  p1IdxLo = 6'd7, p1IdxHi = 6'd57, p2IdxLo = 6'd21, p2IdxHi = 6'd43;
  logic [15:0] p1ValA = 16'h4000, p1ValB = 16'h2000, p2ValA = 16'hC000, p2ValB = 16'h8000;
  logic        inValid = 1'b0, inSof = 1'b0;
  logic [5:0]  inIdx = '0;
  logic [31:0] inDataA = '0, inDataB = '0;
  logic        outValid, outSof;
  logic [5:0]  outIdx;
  logic [31:0] outDataA, outDataB;

  int total = 0, bad = 0, symNo = 0;
  bit finished = 0;
  logic [6:0]  mState = 7'h7F;
  logic        mSign = 1'b0;
  logic [31:0] prevA = '0, prevB = '0;

  always #2 clk = ~clk;

  pilot_inserter u_pilot_inserter (.*);

  task automatic chk(input bit ok, input string tag, input logic [79:0] act, input logic [79:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s idx=%0d act=%h exp=%h", tag, inIdx, act, exp);
    end
  endtask

  function automatic logic [31:0] expOut(input int ant, input logic [5:0] idx,
                                         input logic [31:0] din, input bit sgn);
    logic [15:0] v;
    bit h1, h2;
    if (ant == 1 && sisoMode) return 32'h0;
    h1 = (idx == p1IdxLo) || (idx == p1IdxHi);
    h2 = (idx == p2IdxLo) || (idx == p2IdxHi);
    if (h1)      v = ant ? p1ValB : p1ValA;
    else if (h2) v = ant ? p2ValB : p2ValA;
    else return din;
    if (sgn) v = (v == 16'h8000) ? 16'h7FFF : 16'(-int'($signed(v)));
    return {v, 16'h0};
  endfunction

  task automatic step(input logic [5:0] idx, input bit sof, input bit valid,
                      input bit pkt, input string tagIn);
    logic [31:0] dA, dB, eA, eB;
    bit nb, sgn, hit;
    string tag;
    dA = {10'(symNo), idx, 10'h155, idx};
    dB = ~dA;
    @(negedge clk);
    inIdx = idx; inSof = sof; inValid = valid; pktStart = pkt;
    inDataA = dA; inDataB = dB;
    if (pkt) mState = 7'h7F;
    if (valid && sof) begin
      nb = mState[6] ^ mState[3];
      mState = {mState[5:0], nb};
      mSign = nb;
    end
    sgn = mSign & scrambleEn;
    @(posedge clk);
    #1;
    pktStart = 1'b0;
    if (valid) begin
      eA = expOut(0, idx, dA, sgn);
      eB = expOut(1, idx, dB, sgn);
      hit = (idx == p1IdxLo) || (idx == p1IdxHi) || (idx == p2IdxLo) || (idx == p2IdxHi);
      tag = tagIn;
      if (tag == "") begin
        if (hit && sgn && (eA[31:16] == 16'h7FFF || eB[31:16] == 16'h7FFF)) tag = "R10";
        else if (hit && sgn) tag = "R7";
        else if ((idx == p1IdxLo) || (idx == p1IdxHi)) tag = "R2";
        else if (hit) tag = "R3";
        else tag = "R1";
      end
      chk({outValid, outSof, outIdx, outDataA, outDataB} == {1'b1, sof, idx, eA, eB}, tag,
          80'({outValid, outSof, outIdx, outDataA, outDataB}), 80'({1'b1, sof, idx, eA, eB}));
      prevA = eA; prevB = eB;
    end else begin
      chk({outValid, outSof, outDataA, outDataB} == {2'b00, prevA, prevB}, "R11",
          80'({outValid, outSof, outDataA, outDataB}), 80'({2'b00, prevA, prevB}));
    end
  endtask

  task automatic sym(input string tag, input bit pktAtSof, input bit gaps);
    for (int i = 0; i < 64; i++) begin
      step(6'(i), i == 0, 1'b1, pktAtSof && i == 0, tag);
      if (gaps && (i % 8 == 3)) step(6'(i), 1'b1, 1'b0, 1'b0, "R11");
    end
    symNo++;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state at the ports
    chk({outValid, outSof, outIdx, outDataA, outDataB} == '0, "R12",
        80'({outValid, outSof, outIdx, outDataA, outDataB}), 80'h0);
    rstN = 1'b1;
    // R1 R2 R3 plain insertion, seed sequence starts from reset (R12)
    sym("", 0, 0);
    // R9: reseed on an idle cycle, then scrambled run covering R7 and R10
    step(6'd0, 1'b0, 1'b0, 1'b1, "R9");
    scrambleEn = 1'b1;
    for (int s = 0; s < 6; s++) sym("", 0, 0);
    // R8: disabled scrambling still advances the sequence
    scrambleEn = 1'b0;
    for (int s = 0; s < 2; s++) sym("R8", 0, 0);
    scrambleEn = 1'b1;
    for (int s = 0; s < 3; s++) sym("", 0, 0);
    // R6: single-antenna mode
    sisoMode = 1'b1;
    for (int s = 0; s < 2; s++) sym("R6", 0, 0);
    sisoMode = 1'b0;
    // R9: reseed in the same cycle as start-of-symbol
    sym("R9", 1, 0);
    for (int s = 0; s < 5; s++) sym("", 0, 0);
    // R11: idle gaps with a stray marker
    sym("R11", 0, 1);
    for (int s = 0; s < 2; s++) sym("", 0, 0);
    // R4: overlapping index, pilot 1 wins
    p2IdxLo = 6'd7;
    sym("R4", 0, 0);
    p2IdxLo = 6'd21;
    // R5: distinct per-antenna values
    p1ValB = 16'h1234; p2ValA = 16'h0F0F;
    for (int s = 0; s < 2; s++) sym("R5", 0, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule